// File: doc/BRIEF.md
# Timing Reference Selection Controller

This block is the decision logic of a network synchronization clock unit. It watches health flags for eight candidate timing references and chooses which one the loop should follow. It also runs the operating mode. The mode is free-run on the local oscillator, locked to the chosen reference, or holdover on stored frequency history. The phase-locked loop, its filters and frequency measurement sit outside this block. They feed it a per-input fault flag, a lock-loss flag and a slow qualification tick.

In automatic operation the choice comes from a programmable priority table, with one 4-bit entry per input. An input can also be removed through a mask bit. A revertive setting decides whether the controller moves back to a better input after that input recovers. A register field or a hardware pin field can force a specific input. A separate control can force free-run. Each change of the chosen input raises a one-cycle strobe and a sticky interrupt.

Top module: `ref_sel_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `active_idx` is 0, `op_mode` is 0 (free-run), `switch_stb` and `irq` are 0, and the history counter is cleared.
- R2: `ref_ok[i]` is high only while `ref_fault[i]` is low and at least `qual_limit` cycles with `qual_tick` high have passed since the fault last cleared. A fault drops `ref_ok[i]` in the same cycle.
- R3: In automatic selection (`sel_src` = 0), an input is eligible when it is qualified, unmasked and has a non-zero priority entry. Entry i sits at `prio_table[4*i+3:4*i]`. The chosen input is the eligible one with the smallest entry, and a tie goes to the lower index. An entry of 0 disables the input.
- R4: An input whose `ref_mask` bit is 1 is never chosen automatically.
- R5: With `revertive` = 1, the controller moves to the best eligible input on the edge after that input becomes eligible.
- R6: With `revertive` = 0, the controller keeps the current input for as long as that input stays eligible.
- R7: With `sel_src` = 1, a `man_sel` value below 8 sets `active_idx` to that value on the next edge. The mode is locked if that input is qualified. A value of 8 or more falls back to automatic selection.
- R8: With `sel_src` = 2, `pin_sel` acts in the same way as `man_sel` does in R7.
- R9: With `sel_src` = 3, the mode goes to free-run on the next edge and `active_idx` holds.
- R10: When no target is usable, the mode becomes holdover (2) if the current mode is not free-run and `holdover_avail` is high. Otherwise the mode becomes free-run. A usable target is an eligible input, or the forced input when it is qualified.
- R11: `holdover_avail` is high when the history count is at or above `hold_limit`. The count rises on each `qual_tick` while the mode is locked and `lock_lost` is low. It clears while the mode is free-run or `lock_lost` is high.
- R12: `switch_stb` is high for exactly the one cycle after each edge at which `active_idx` changes.
- R13: `irq` is set by a change of `active_idx` or by a rising `lock_lost`. It stays set until a cycle with `irq_clr` high and no new set event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_fault | input | 8 | Per-input loss-of-signal flag |
| lock_lost | input | 1 | Loss-of-lock flag from the loop |
| qual_tick | input | 1 | Slow qualification and history tick |
| qual_limit | input | 8 | Ticks an input must be clean before it qualifies |
| hold_limit | input | 8 | Locked ticks needed before holdover is allowed |
| prio_table | input | 32 | Eight 4-bit priority entries, input 0 in the low bits |
| ref_mask | input | 8 | 1 removes the input from automatic choice |
| revertive | input | 1 | 1 returns to a better input after it recovers |
| sel_src | input | 2 | 0 auto, 1 register select, 2 pin select, 3 force free-run |
| man_sel | input | 4 | Register-driven forced input |
| pin_sel | input | 4 | Pin-driven forced input |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq` |
| active_idx | output | 3 | Index of the chosen input |
| op_mode | output | 2 | 0 free-run, 1 locked, 2 holdover |
| holdover_avail | output | 1 | Enough locked history for holdover |
| switch_stb | output | 1 | One-cycle pulse on every change of input |
| irq | output | 1 | Sticky interrupt |
| ref_ok | output | 8 | Per-input qualified status |

## Verification
Some properties are checked by assertions on every cycle. The strobe only appears together with a real index change and a set interrupt. The interrupt stays set without a clear. Holdover is only entered while history was available. Forced free-run is obeyed. An automatic lock never lands on a masked input. The bench scenarios are needed for the rest. These cover qualification counting, priority order and tie breaks, the revertive and non-revertive choices, manual and pin overrides with out-of-range values, and the build-up of history. A cycle-level reference model covers all of them during long random runs.

// File: rtl/ref_sel_pkg.sv
// Shared encodings for the reference selection controller.
// Assumes: two-bit mode and source fields at the top-level ports.
package ref_sel_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_LOCK = 2'd1,
        MODE_HOLD = 2'd2
    } op_mode_e;

    localparam logic [1:0] SRC_AUTO = 2'd0;
    localparam logic [1:0] SRC_REG  = 2'd1;
    localparam logic [1:0] SRC_PIN  = 2'd2;
    localparam logic [1:0] SRC_FREE = 2'd3;

endpackage

// File: rtl/ref_qualifier.sv
// Per-input qualification: counts clean ticks after a fault clears and
// reports the input usable once the count reaches the limit.
// Assumes: fault is synchronous to clk; limit may change at any time.
module ref_qualifier #(
    parameter int QUAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic              tick,
    input  logic [QUAL_W-1:0] limit,
    output logic              ok
);

    logic [QUAL_W-1:0] clean_cnt;

    // Clean-tick counter: cleared by a fault, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_cnt <= '0;
        end else if (fault) begin
            clean_cnt <= '0;
        end else if (tick && (clean_cnt < limit)) begin
            clean_cnt <= clean_cnt + 1'b1;
        end
    end

    // Usable status: a fault withdraws it within the same cycle.
    assign ok = !fault && (clean_cnt >= limit);

endmodule

// File: rtl/prio_picker.sv
// Combinational best-candidate search over the priority table.
// Assumes: eligibility already excludes disabled (zero) entries;
// a smaller entry wins and an equal entry goes to the lower index.
module prio_picker #(
    parameter int N      = 8,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]        eligible,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic                found,
    output logic [IDX_W-1:0]    best_idx
);

    logic [PRIO_W-1:0] best_p;

    // Linear scan with strict comparison so ties keep the lower index.
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_p   = '1;
        for (int i = 0; i < N; i++) begin
            if (eligible[i] && (!found || (prio_flat[i*PRIO_W +: PRIO_W] < best_p))) begin
                found    = 1'b1;
                best_idx = IDX_W'(i);
                best_p   = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/hold_history.sv
// Tracks how long the loop has been locked cleanly, to decide whether
// holdover history is trustworthy.
// Assumes: mode inputs come from the registered operating mode.
module hold_history #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_lock,
    input  logic              in_free,
    input  logic              lock_lost,
    input  logic              tick,
    input  logic [HIST_W-1:0] limit,
    output logic              avail
);

    logic [HIST_W-1:0] hist_cnt;

    // History counter: cleared in free-run or on lock loss, counts locked ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_cnt <= '0;
        end else if (in_free || lock_lost) begin
            hist_cnt <= '0;
        end else if (in_lock && tick && (hist_cnt < limit)) begin
            hist_cnt <= hist_cnt + 1'b1;
        end
    end

    // Availability compares the stored history with the programmed need.
    assign avail = (hist_cnt >= limit);

endmodule

// File: rtl/ref_sel_ctrl.sv
// Reference selection controller top: qualifies eight inputs, picks the
// active one by priority, mask, revertivity or forced select, and runs
// the free-run / locked / holdover mode with strobe and sticky interrupt.
// Assumes: all inputs synchronous to clk; irq_clr is a one-cycle strobe.
module ref_sel_ctrl
    import ref_sel_pkg::*;
#(
    parameter int N      = 8,
    parameter int PRIO_W = 4,
    parameter int QUAL_W = 8,
    parameter int HIST_W = 8,
    localparam int IDX_W = $clog2(N),
    localparam int SEL_W = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        ref_fault,
    input  logic                lock_lost,
    input  logic                qual_tick,
    input  logic [QUAL_W-1:0]   qual_limit,
    input  logic [HIST_W-1:0]   hold_limit,
    input  logic [N*PRIO_W-1:0] prio_table,
    input  logic [N-1:0]        ref_mask,
    input  logic                revertive,
    input  logic [1:0]          sel_src,
    input  logic [SEL_W-1:0]    man_sel,
    input  logic [SEL_W-1:0]    pin_sel,
    input  logic                irq_clr,
    output logic [IDX_W-1:0]    active_idx,
    output logic [1:0]          op_mode,
    output logic                holdover_avail,
    output logic                switch_stb,
    output logic                irq,
    output logic [N-1:0]        ref_ok
);

    localparam logic [SEL_W-1:0] N_SEL = SEL_W'(N);

    op_mode_e         cur_mode, nxt_mode, fallback;
    logic [IDX_W-1:0] cur_idx, nxt_idx, man_idx, best_idx;
    logic [N-1:0]     eligible;
    logic             any_elig, man_valid, lol_d, set_evt;

    // One qualifier per input, plus the eligibility term.
    for (genvar g = 0; g < N; g++) begin : g_ref
        ref_qualifier #(.QUAL_W(QUAL_W)) qual_i (
            .clk   (clk),
            .rst_n (rst_n),
            .fault (ref_fault[g]),
            .tick  (qual_tick),
            .limit (qual_limit),
            .ok    (ref_ok[g])
        );
        assign eligible[g] = ref_ok[g] && !ref_mask[g] &&
                             (prio_table[g*PRIO_W +: PRIO_W] != '0);
    end

    prio_picker #(.N(N), .PRIO_W(PRIO_W)) pick_i (
        .eligible  (eligible),
        .prio_flat (prio_table),
        .found     (any_elig),
        .best_idx  (best_idx)
    );

    hold_history #(.HIST_W(HIST_W)) hist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_lock   (cur_mode == MODE_LOCK),
        .in_free   (cur_mode == MODE_FREE),
        .lock_lost (lock_lost),
        .tick      (qual_tick),
        .limit     (hold_limit),
        .avail     (holdover_avail)
    );

    // Decode a forced selection from register or pin, rejecting out-of-range values.
    always_comb begin
        man_valid = 1'b0;
        man_idx   = '0;
        if ((sel_src == SRC_REG) && (man_sel < N_SEL)) begin
            man_valid = 1'b1;
            man_idx   = man_sel[IDX_W-1:0];
        end else if ((sel_src == SRC_PIN) && (pin_sel < N_SEL)) begin
            man_valid = 1'b1;
            man_idx   = pin_sel[IDX_W-1:0];
        end
    end

    // Next index and mode from the override source, candidates and history.
    always_comb begin
        nxt_idx  = cur_idx;
        nxt_mode = cur_mode;
        fallback = ((cur_mode != MODE_FREE) && holdover_avail) ? MODE_HOLD : MODE_FREE;
        if (sel_src == SRC_FREE) begin
            nxt_mode = MODE_FREE;
        end else if (man_valid) begin
            nxt_idx  = man_idx;
            nxt_mode = ref_ok[man_idx] ? MODE_LOCK : fallback;
        end else if (any_elig) begin
            if (revertive || !eligible[cur_idx]) begin
                nxt_idx = best_idx;
            end
            nxt_mode = MODE_LOCK;
        end else begin
            nxt_mode = fallback;
        end
    end

    assign set_evt = (nxt_idx != cur_idx) || (lock_lost && !lol_d);

    // State, strobe and sticky interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx    <= '0;
            cur_mode   <= MODE_FREE;
            switch_stb <= 1'b0;
            irq        <= 1'b0;
            lol_d      <= 1'b0;
        end else begin
            cur_idx    <= nxt_idx;
            cur_mode   <= nxt_mode;
            switch_stb <= (nxt_idx != cur_idx);
            lol_d      <= lock_lost;
            if (set_evt) begin
                irq <= 1'b1;
            end else if (irq_clr) begin
                irq <= 1'b0;
            end
        end
    end

    assign active_idx = cur_idx;
    assign op_mode    = cur_mode;

endmodule

// File: rtl/ref_sel_ctrl_chk.sv
// Port-level checker for the reference selection controller, bound below.
// Assumes: the same parameters as the bound instance.
module ref_sel_ctrl_chk #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     ref_mask,
    input logic [1:0]       sel_src,
    input logic             irq_clr,
    input logic [IDX_W-1:0] active_idx,
    input logic [1:0]       op_mode,
    input logic             holdover_avail,
    input logic             switch_stb,
    input logic             irq
);

    logic [N-1:0] mask_d;
    logic [1:0]   src_d;

    // Sample the inputs that the registered outputs were decided from.
    always_ff @(posedge clk) begin
        mask_d <= ref_mask;
        src_d  <= sel_src;
    end

    // R12
    stb_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_stb |-> (active_idx != $past(active_idx)));

    // R13
    stb_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_stb |-> irq);

    // R13
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R10
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'd2 && $past(op_mode) != 2'd2) |-> $past(holdover_avail));

    // R9
    forced_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_src) == 2'd3) |-> (op_mode == 2'd0));

    // R4
    no_masked_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'd1 && src_d == 2'd0) |-> !mask_d[active_idx]);

endmodule

bind ref_sel_ctrl ref_sel_ctrl_chk #(.N(N)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ref_mask       (ref_mask),
    .sel_src        (sel_src),
    .irq_clr        (irq_clr),
    .active_idx     (active_idx),
    .op_mode        (op_mode),
    .holdover_avail (holdover_avail),
    .switch_stb     (switch_stb),
    .irq            (irq)
);

// File: tb/ref_sel_ctrl_tb_top.sv
// Bench: directed corner cases followed by seeded random stimulus, all
// compared each cycle against a reference model built from the requirements.
module ref_sel_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ref_fault = '0;
    logic        lock_lost = 1'b0;
    logic        qual_tick = 1'b0;
    logic [7:0]  qual_limit = 8'd2;
    logic [7:0]  hold_limit = 8'd5;
    logic [31:0] prio_table = '0;
    logic [7:0]  ref_mask = '0;
    logic        revertive = 1'b0;
    logic [1:0]  sel_src = 2'd0;
    logic [3:0]  man_sel = '0;
    logic [3:0]  pin_sel = '0;
    logic        irq_clr = 1'b0;
    logic [2:0]  active_idx;
    logic [1:0]  op_mode;
    logic        holdover_avail, switch_stb, irq;
    logic [7:0]  ref_ok;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // Model state
    int mq[8];
    int mcur = 0, mmode = 0, mhist = 0;
    bit mstb = 0, mirq = 0, mlol = 0;

    always #10 clk = ~clk;

    ref_sel_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ref_fault(ref_fault), .lock_lost(lock_lost),
        .qual_tick(qual_tick), .qual_limit(qual_limit), .hold_limit(hold_limit),
        .prio_table(prio_table), .ref_mask(ref_mask), .revertive(revertive),
        .sel_src(sel_src), .man_sel(man_sel), .pin_sel(pin_sel), .irq_clr(irq_clr),
        .active_idx(active_idx), .op_mode(op_mode), .holdover_avail(holdover_avail),
        .switch_stb(switch_stb), .irq(irq), .ref_ok(ref_ok)
    );

    function automatic bit m_ok(int i);
        return !ref_fault[i] && (mq[i] >= int'(qual_limit));
    endfunction

    function automatic bit m_elig(int i);
        return m_ok(i) && !ref_mask[i] && (prio_table[i*4 +: 4] != 4'd0);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Model advance for one edge, from requirements R1..R13.
    task automatic model_update();
        int  best, bp, nidx, nmode, fb, tgt;
        bit  found, tvalid;
        if (!rst_n) begin
            foreach (mq[i]) mq[i] = 0;
            mcur = 0; mmode = 0; mhist = 0; mstb = 0; mirq = 0; mlol = 0;
            return;
        end
        found = 0; best = 0; bp = 99;
        for (int i = 0; i < 8; i++)
            if (m_elig(i) && int'(prio_table[i*4 +: 4]) < bp) begin
                found = 1; best = i; bp = int'(prio_table[i*4 +: 4]);
            end
        tvalid = 0; tgt = 0;
        if (sel_src == 2'd1 && man_sel < 4'd8) begin tvalid = 1; tgt = int'(man_sel); end
        if (sel_src == 2'd2 && pin_sel < 4'd8) begin tvalid = 1; tgt = int'(pin_sel); end
        fb = (mmode != 0 && mhist >= int'(hold_limit)) ? 2 : 0;
        nidx = mcur; nmode = mmode;
        if (sel_src == 2'd3) nmode = 0;
        else if (tvalid) begin nidx = tgt; nmode = m_ok(tgt) ? 1 : fb; end
        else if (found) begin
            if (revertive || !m_elig(mcur)) nidx = best;
            nmode = 1;
        end else nmode = fb;
        for (int i = 0; i < 8; i++) begin
            if (ref_fault[i]) mq[i] = 0;
            else if (qual_tick && mq[i] < int'(qual_limit)) mq[i]++;
        end
        if (mmode == 0 || lock_lost) mhist = 0;
        else if (mmode == 1 && qual_tick && mhist < int'(hold_limit)) mhist++;
        if (nidx != mcur || (lock_lost && !mlol)) mirq = 1;
        else if (irq_clr) mirq = 0;
        mstb = (nidx != mcur);
        mlol = lock_lost;
        mcur = nidx; mmode = nmode;
    endtask

    task automatic compare_all();
        for (int i = 0; i < 8; i++) begin
            n_vec++;
            if (ref_ok[i] != m_ok(i)) begin
                n_bad++;
                $display("FAIL R2 ref_ok[%0d]: actual %0d expected %0d", i, ref_ok[i], m_ok(i));
            end
        end
        chk("R3", "active_idx", int'(active_idx), mcur);
        chk("R10", "op_mode", int'(op_mode), mmode);
        chk("R11", "holdover_avail", int'(holdover_avail), int'(mhist >= int'(hold_limit)));
        chk("R12", "switch_stb", int'(switch_stb), int'(mstb));
        chk("R13", "irq", int'(irq), int'(mirq));
    endtask

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            model_update();
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        cyc(3);
        // R1: reset state
        chk("R1", "reset idx", int'(active_idx), 0);
        chk("R1", "reset mode", int'(op_mode), 0);
        chk("R1", "reset stb", int'(switch_stb), 0);
        chk("R1", "reset irq", int'(irq), 0);
        chk("R1", "reset avail", int'(holdover_avail), 0);
        rst_n = 1'b1;
        prio_table[2*4 +: 4] = 4'd3;
        prio_table[5*4 +: 4] = 4'd3;
        qual_tick = 1'b1;
        cyc(1);
        chk("R2", "ref2 not yet qualified", int'(ref_ok[2]), 0);
        cyc(1);
        chk("R2", "ref2 qualified", int'(ref_ok[2]), 1);
        cyc(1);
        chk("R3", "tie to lower index", int'(active_idx), 2);
        chk("R3", "locked", int'(op_mode), 1);
        ref_mask = 8'h04;
        cyc(1);
        chk("R4", "masked skipped", int'(active_idx), 5);
        ref_mask = 8'h00;
        cyc(2);
        chk("R6", "non-revertive stays", int'(active_idx), 5);
        revertive = 1'b1;
        cyc(1);
        chk("R5", "revert to better", int'(active_idx), 2);
        hold_limit = 8'd3;
        cyc(6);
        chk("R11", "history built", int'(holdover_avail), 1);
        ref_fault = 8'hFF;
        cyc(1);
        chk("R10", "holdover entered", int'(op_mode), 2);
        sel_src = 2'd3;
        cyc(1);
        chk("R9", "forced free-run", int'(op_mode), 0);
        chk("R9", "index held", int'(active_idx), 2);
        cyc(2);
        chk("R11", "history cleared", int'(holdover_avail), 0);
        sel_src = 2'd0;
        cyc(1);
        chk("R10", "no holdover from free-run", int'(op_mode), 0);
        ref_fault = 8'h00;
        sel_src = 2'd1; man_sel = 4'd6;
        cyc(1);
        chk("R7", "register select", int'(active_idx), 6);
        cyc(3);
        chk("R7", "register select locks", int'(op_mode), 1);
        man_sel = 4'd9;
        cyc(1);
        chk("R7", "out-of-range falls to auto", int'(active_idx), 2);
        sel_src = 2'd2; pin_sel = 4'd3;
        cyc(1);
        chk("R8", "pin select", int'(active_idx), 3);
        irq_clr = 1'b1;
        cyc(1);
        chk("R13", "irq cleared", int'(irq), 0);
        irq_clr = 1'b0; pin_sel = 4'd1;
        cyc(1);
        chk("R12", "strobe on change", int'(switch_stb), 1);
        chk("R13", "irq set on change", int'(irq), 1);
        cyc(1);
        chk("R12", "strobe one cycle", int'(switch_stb), 0);
        // Random phase, checked by the model every cycle.
        for (int k = 0; k < 4000; k++) begin
            for (int b = 0; b < 8; b++)
                if ($urandom_range(15) == 0) ref_fault[b] = ~ref_fault[b];
            qual_tick = ($urandom_range(1) == 1);
            if ($urandom_range(39) == 0) lock_lost = ~lock_lost;
            irq_clr = ($urandom_range(7) == 0);
            if ($urandom_range(63) == 0)
                for (int b = 0; b < 8; b++) prio_table[b*4 +: 4] = 4'($urandom_range(15));
            if ($urandom_range(31) == 0) ref_mask = 8'($urandom_range(255)) & 8'($urandom_range(255));
            if ($urandom_range(63) == 0) revertive = ~revertive;
            if ($urandom_range(49) == 0) begin
                int r = $urandom_range(9);
                sel_src = (r < 6) ? 2'd0 : 2'(r - 6);
                man_sel = 4'($urandom_range(15));
                pin_sel = 4'($urandom_range(15));
            end
            if ($urandom_range(99) == 0) begin
                qual_limit = 8'($urandom_range(3));
                hold_limit = 8'($urandom_range(7));
            end
            if (k == 2000) rst_n = 1'b0;
            if (k == 2003) rst_n = 1'b1;
            cyc(1);
        end
        finish_run();
    end

endmodule